// File: doc/BRIEF.md
# Interrupt and DMA Request Prioritizer

This block holds the three interrupt pending flags of a two-wire serial peripheral: error, receive-data-ready and transmit-ready. The serial engine sets them with single-cycle event strobes. Software can only clear them, by writing zeros through an 8-bit register port. The same register carries a 3-bit priority level, which goes straight out to the system interrupt controller.

A fixed combinational arbiter ranks the pending interrupts together with the receive and transmit DMA requests, and presents one winner as a one-hot grant. The error interrupt ranks above the DMA requests when DMA-stop mode is on, and below them when it is off. While any error or event status flag from the serial engine is high, the error pending bit is held at 1, so that software cannot lose an unserviced error.

Top module: `irq_dma_prioritizer`

## Requirements
- R1: After reset the register reads 8'hF0: bit 7 is 1, the priority level is 7, bit 3 is 0 and all pending bits are 0. No grant is given.
- R2: The register reads as {1, level[2:0], 0, err_pend, rx_pend, tx_pend}, from bit 7 down to bit 0. Writes to bits 7 and 3 have no effect on what is read.
- R3: An event strobe sets its pending bit in the register one cycle after the strobe, but only when `irq_en` is 1. With `irq_en` at 0 the strobe leaves the bit unchanged.
- R4: A register write clears each pending bit whose written bit (2, 1 or 0) is 0. A pending bit whose written bit is 1 keeps its value.
- R5: When a set event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R6: While `irq_en` is 1 and any bit of `err_flags` is high, the error pending bit reads 1, even after a write that clears it.
- R7: A register write loads bits 6:4 into the priority level, which appears on `prio_level` one cycle later.
- R8: When the priority level is 7, `grant` is zero and `grant_valid` is 0, whatever is pending.
- R9: With `dma_stop`=1 the order from highest to lowest is: error (grant bit 0), receive DMA (bit 1), transmit DMA (bit 2), receive interrupt (bit 4), transmit interrupt (bit 5).
- R10: With `dma_stop`=0 the error interrupt is granted on bit 3, below both DMA requests and above the receive and transmit interrupts. Grant bit 0 is never used in this mode.
- R11: A DMA source takes part in arbitration only while both its request input and its enable input are high.
- R12: `grant` has at most one bit set, and `grant_valid` is 1 exactly when a bit is set. The grant follows its inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| irq_en | input | 1 | Interrupt enable; gates setting and forcing of the pending bits |
| err_evt | input | 1 | Error event strobe |
| rx_evt | input | 1 | Receive data / end-of-block strobe |
| tx_evt | input | 1 | Transmit ready / end-of-block strobe |
| err_flags | input | NUM_FLAGS | Error and event status flags that force the error pending bit |
| dma_stop | input | 1 | Selects the rank of the error interrupt |
| rx_dma_req | input | 1 | Receive DMA request |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_dma_req | input | 1 | Transmit DMA request |
| tx_dma_en | input | 1 | Transmit DMA enable |
| prio_level | output | LVL_W | Priority level sent to the interrupt controller |
| grant | output | 6 | One-hot winner, indexed by rank slot |
| grant_valid | output | 1 | A grant is active |

## Verification
The bench builds the block with its default parameters: eight status flags and a 3-bit level. With these values the no-request level 7 can be reached with a single write, and forcing is exercised from a single flag in the middle of the flag vector. The directed tasks step through every rank of both orders by removing the current winner one source at a time. They also cover a set that collides with a clear, and the DMA-enable gating.

// File: rtl/irqp_pkg.sv
// Shared constants of the interrupt/DMA prioritizer.
// Assumes: rank slots are fixed; pending bit positions match the register.
package irqp_pkg;
    localparam int NUM_SLOT  = 6;
    localparam int NUM_PEND  = 3;
    // pending bit positions inside the register
    localparam int PB_TX     = 0;
    localparam int PB_RX     = 1;
    localparam int PB_ERR    = 2;
    // rank slots, lowest index wins
    localparam int SL_ERR_HI = 0;
    localparam int SL_RXDMA  = 1;
    localparam int SL_TXDMA  = 2;
    localparam int SL_ERR_LO = 3;
    localparam int SL_RXINT  = 4;
    localparam int SL_TXINT  = 5;
endpackage

// File: rtl/irqp_pending.sv
// Pending flag bank: hardware sets (gated by enable), software clears by
// writing zeros, set wins over clear, and the error bit is held high while
// any status flag is asserted. Assumes strobes are synchronous to clk.
module irqp_pending #(
    parameter int NUM_FLAGS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          irq_en,
    input  logic [irqp_pkg::NUM_PEND-1:0] set_evt,
    input  logic                          wr_en,
    input  logic [irqp_pkg::NUM_PEND-1:0] wr_bits,
    input  logic [NUM_FLAGS-1:0]          err_flags,
    output logic [irqp_pkg::NUM_PEND-1:0] pend
);
    import irqp_pkg::*;

    logic force_err;
    // Error forcing request from any status flag
    always_comb force_err = irq_en & (|err_flags);

    for (genvar b = 0; b < NUM_PEND; b++) begin : g_bit
        logic do_set;
        logic do_clr;
        // Set and clear decode for this bit
        always_comb begin
            do_set = irq_en & set_evt[b];
            if (b == PB_ERR) do_set = do_set | force_err;
            do_clr = wr_en & ~wr_bits[b];
        end
        // Pending flop: reset, then set beats clear
        always_ff @(posedge clk) begin
            if (!rst_n)      pend[b] <= 1'b0;
            else if (do_set) pend[b] <= 1'b1;
            else if (do_clr) pend[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/irqp_level_reg.sv
// Priority level register, loaded on every register write.
// Assumes reset value is the all-ones "no request" level.
module irqp_level_reg #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_lvl,
    output logic [LVL_W-1:0] lvl
);
    // Level storage with reset to the idle level
    always_ff @(posedge clk) begin
        if (!rst_n)     lvl <= '1;
        else if (wr_en) lvl <= wr_lvl;
    end
endmodule

// File: rtl/irqp_arbiter.sv
// Fixed-order combinational arbiter over the rank slots; slot 0 wins.
// Assumes req is already mapped to slots; allow=0 blocks every grant.
module irqp_arbiter #(
    parameter int N = 6
) (
    input  logic         allow,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         valid
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        if (i == 0) begin : g_top
            // Highest slot needs only its own request
            always_comb grant[i] = allow & req[i];
        end else begin : g_rest
            // Lower slot wins only if no higher slot requests
            always_comb grant[i] = allow & req[i] & ~(|req[i-1:0]);
        end
    end
    // Valid when any slot was granted
    always_comb valid = |grant;
endmodule

// File: rtl/irq_dma_prioritizer.sv
// Top: register port, pending bank, level register and slot arbiter.
// Assumes a single clock domain and synchronous active-low reset.
module irq_dma_prioritizer #(
    parameter int NUM_FLAGS = 8,
    parameter int LVL_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_data,
    output logic [7:0]           rd_data,
    input  logic                 irq_en,
    input  logic                 err_evt,
    input  logic                 rx_evt,
    input  logic                 tx_evt,
    input  logic [NUM_FLAGS-1:0] err_flags,
    input  logic                 dma_stop,
    input  logic                 rx_dma_req,
    input  logic                 rx_dma_en,
    input  logic                 tx_dma_req,
    input  logic                 tx_dma_en,
    output logic [LVL_W-1:0]     prio_level,
    output logic [5:0]           grant,
    output logic                 grant_valid
);
    import irqp_pkg::*;

    localparam logic [LVL_W-1:0] LVL_NONE = '1;

    logic [NUM_PEND-1:0] pend;
    logic [NUM_PEND-1:0] set_evt;
    logic [NUM_SLOT-1:0] req;
    logic                allow;
    logic                unused_wr;

    // Gather event strobes by pending bit position
    always_comb begin
        set_evt         = '0;
        set_evt[PB_TX]  = tx_evt;
        set_evt[PB_RX]  = rx_evt;
        set_evt[PB_ERR] = err_evt;
    end

    // Reserved write bits are discarded
    assign unused_wr = ^{wr_data[7], wr_data[3]};

    irqp_pending #(.NUM_FLAGS(NUM_FLAGS)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_en   (irq_en),
        .set_evt  (set_evt),
        .wr_en    (wr_en),
        .wr_bits  (wr_data[NUM_PEND-1:0]),
        .err_flags(err_flags),
        .pend     (pend)
    );

    irqp_level_reg #(.LVL_W(LVL_W)) u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .wr_lvl(wr_data[4 +: LVL_W]),
        .lvl   (prio_level)
    );

    // Map sources onto rank slots; error slot chosen by DMA-stop mode
    always_comb begin
        req            = '0;
        req[SL_ERR_HI] = pend[PB_ERR] & dma_stop;
        req[SL_RXDMA]  = rx_dma_req & rx_dma_en;
        req[SL_TXDMA]  = tx_dma_req & tx_dma_en;
        req[SL_ERR_LO] = pend[PB_ERR] & ~dma_stop;
        req[SL_RXINT]  = pend[PB_RX];
        req[SL_TXINT]  = pend[PB_TX];
        allow          = (prio_level != LVL_NONE);
    end

    irqp_arbiter #(.N(NUM_SLOT)) u_arb (
        .allow(allow),
        .req  (req),
        .grant(grant),
        .valid(grant_valid)
    );

    // Register read view
    always_comb begin
        rd_data = '0;
        rd_data[7] = 1'b1;
        rd_data[4 +: LVL_W] = prio_level;
        rd_data[NUM_PEND-1:0] = pend;
    end
endmodule

// File: rtl/irqp_checker.sv
// Property checker for the prioritizer, attached by bind.
module irqp_checker #(
    parameter int NUM_FLAGS = 8,
    parameter int LVL_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [7:0]           wr_data,
    input logic [7:0]           rd_data,
    input logic                 irq_en,
    input logic                 err_evt,
    input logic                 rx_evt,
    input logic                 tx_evt,
    input logic [NUM_FLAGS-1:0] err_flags,
    input logic                 dma_stop,
    input logic [LVL_W-1:0]     prio_level,
    input logic [5:0]           grant,
    input logic                 grant_valid
);
    assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] && !rd_data[3]);
    assert_rx_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en && rx_evt |=> rd_data[1]);
    assert_keep_on_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] && wr_en && wr_data[0] |=> rd_data[0]);
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en && tx_evt && wr_en && !wr_data[0] |=> rd_data[0]);
    assert_err_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en && (|err_flags) |=> rd_data[2]);
    assert_level_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> prio_level == $past(wr_data[4 +: LVL_W]));
    assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (&prio_level) |-> !grant_valid);
    assert_no_hi_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_stop |-> !grant[0]);
    assert_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (grant_valid == (grant != 6'd0)));
    // err_evt is covered through R3-style behaviour of its own bit
    assert_err_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en && err_evt |=> rd_data[2]);
endmodule

bind irq_dma_prioritizer irqp_checker #(.NUM_FLAGS(NUM_FLAGS), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_en(irq_en), .err_evt(err_evt), .rx_evt(rx_evt),
    .tx_evt(tx_evt), .err_flags(err_flags), .dma_stop(dma_stop),
    .prio_level(prio_level), .grant(grant), .grant_valid(grant_valid)
);

// File: tb/test_irq_dma_prioritizer.sv
// Directed bench for the interrupt/DMA prioritizer.
module test_irq_dma_prioritizer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_en = 1'b0;
    logic       err_evt = 1'b0, rx_evt = 1'b0, tx_evt = 1'b0;
    logic [7:0] err_flags = '0;
    logic       dma_stop = 1'b0;
    logic       rx_dma_req = 1'b0, rx_dma_en = 1'b0;
    logic       tx_dma_req = 1'b0, tx_dma_en = 1'b0;
    logic [2:0] prio_level;
    logic [5:0] grant;
    logic       grant_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_dma_prioritizer i_irq_dma_prioritizer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq_en(irq_en), .err_evt(err_evt),
        .rx_evt(rx_evt), .tx_evt(tx_evt), .err_flags(err_flags),
        .dma_stop(dma_stop), .rx_dma_req(rx_dma_req), .rx_dma_en(rx_dma_en),
        .tx_dma_req(tx_dma_req), .tx_dma_en(tx_dma_en),
        .prio_level(prio_level), .grant(grant), .grant_valid(grant_valid)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Register write: drive at negedge, result visible just after posedge
    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // One-cycle event strobes
    task automatic evt(input logic e, input logic r, input logic t);
        @(negedge clk);
        err_evt = e; rx_evt = r; tx_evt = t;
        @(posedge clk); #1;
        err_evt = 1'b0; rx_evt = 1'b0; tx_evt = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset read", rd_data, 8'hF0);
        chk("R1 reset grant", {1'b0, grant_valid, grant}, 8'h00);
        chk("R1 reset level", {5'd0, prio_level}, 8'd7);
    endtask

    task automatic t_layout_level;
        wr(8'b0_010_1_111);
        chk("R2 reserved bits and ones write", rd_data, 8'hA0);
        chk("R7 level loaded", {5'd0, prio_level}, 8'd2);
    endtask

    task automatic t_set_enable;
        irq_en = 1'b0;
        evt(1, 1, 1);
        chk("R3 no set when disabled", rd_data, 8'hA0);
        irq_en = 1'b1;
        evt(1, 1, 1);
        chk("R3 set when enabled", rd_data, 8'hA7);
    endtask

    task automatic t_clear;
        wr(8'hA5);
        chk("R4 clear rx only", rd_data, 8'hA5);
        wr(8'hA0);
        chk("R4 clear all", rd_data, 8'hA0);
    endtask

    task automatic t_set_wins;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hA0; tx_evt = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; tx_evt = 1'b0;
        chk("R5 set beats clear", rd_data, 8'hA1);
        wr(8'hA0);
    endtask

    task automatic t_force;
        @(negedge clk); err_flags = 8'h20;
        @(posedge clk); #1;
        chk("R6 forced by flag", rd_data, 8'hA4);
        wr(8'hA0);
        chk("R6 clear ignored while flag", rd_data, 8'hA4);
        @(negedge clk); err_flags = 8'h00;
        wr(8'hA0);
        chk("R6 clear after flag drop", rd_data, 8'hA0);
    endtask

    task automatic t_order_stop1;
        evt(1, 1, 1);
        @(negedge clk);
        dma_stop = 1'b1; rx_dma_req = 1; rx_dma_en = 1; tx_dma_req = 1; tx_dma_en = 1;
        #1;
        chk("R9 error first", {1'b0, grant_valid, grant}, 8'h41);
        wr(8'hA3);
        chk("R9 rx dma second", {1'b0, grant_valid, grant}, 8'h42);
        @(negedge clk); rx_dma_req = 0; #1;
        chk("R9 tx dma third", {1'b0, grant_valid, grant}, 8'h44);
        @(negedge clk); tx_dma_req = 0; #1;
        chk("R9 rx int fourth", {1'b0, grant_valid, grant}, 8'h50);
        wr(8'hA1);
        chk("R9 tx int last", {1'b0, grant_valid, grant}, 8'h60);
        wr(8'hA0);
        chk("R12 nothing pending", {1'b0, grant_valid, grant}, 8'h00);
    endtask

    task automatic t_order_stop0;
        evt(1, 1, 0);
        @(negedge clk);
        dma_stop = 1'b0; rx_dma_req = 1; tx_dma_req = 1; #1;
        chk("R10 rx dma above error", {1'b0, grant_valid, grant}, 8'h42);
        @(negedge clk); rx_dma_req = 0; #1;
        chk("R10 tx dma above error", {1'b0, grant_valid, grant}, 8'h44);
        @(negedge clk); tx_dma_req = 0; #1;
        chk("R10 error in low slot", {1'b0, grant_valid, grant}, 8'h48);
    endtask

    task automatic t_dma_en;
        wr(8'hA0);
        @(negedge clk); rx_dma_req = 1; rx_dma_en = 0; tx_dma_req = 1; tx_dma_en = 0; #1;
        chk("R11 requests without enable", {1'b0, grant_valid, grant}, 8'h00);
        @(negedge clk); tx_dma_en = 1; #1;
        chk("R11 tx dma enabled", {1'b0, grant_valid, grant}, 8'h44);
    endtask

    task automatic t_idle_level;
        evt(1, 1, 1);
        wr(8'hF7);
        chk("R8 level 7 blocks grant", {1'b0, grant_valid, grant}, 8'h00);
        chk("R8 pending still held", rd_data, 8'hF7);
        wr(8'h07);
        chk("R7 level 0 re-enables", {1'b0, grant_valid, grant}, 8'h44);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_layout_level();
        t_set_enable();
        t_clear();
        t_set_wins();
        t_force();
        t_order_stop1();
        t_order_stop0();
        t_dma_en();
        t_idle_level();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule